// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits in front of a small register file. It forms a 9-bit data address and splits it into four banks of 128 bytes. The high two address bits select the bank and the low seven select an offset inside that bank. The address can be formed in one of two ways. In direct mode the seven offset bits come from the instruction operand and the two bank bits come from the status register. In indirect mode eight bits come from a file-select pointer and the ninth bit comes from a separate status bit.

Offsets 00h to 1Fh of every bank are special-function registers. The block does not hold these registers. It forwards the address, the strobes and the write data to a separate port and returns that port's read data. The block holds the general-purpose RAM itself: 96 bytes in bank 0 and 32 bytes in bank 1. The top sixteen offsets of every bank lead to one shared group of bank 0 bytes. Every other location is a hole: it reads as zero and ignores writes.

Top module: `banked_file_decoder`

## Requirements
- R1: With indirectMode low, dataAddr equals {bankSel[1], bankSel[0], opAddr[6:0]}. bankSel 00, 01, 10 and 11 select banks 0, 1, 2 and 3.
- R2: With indirectMode high, dataAddr equals {indBank, fileSel[7:0]}.
- R3: Bank 0 addresses 020h to 06Fh are RAM. A byte written there is returned by a read of the same address in any later cycle.
- R4: Bank 1 addresses 0A0h to 0BFh are RAM, separate from bank 0, and behave in the same way as R3.
- R5: Offsets 70h to 7Fh of banks 0 to 3 (addresses 070h, 0F0h, 170h and 1F0h, each plus the same low nibble) are one shared byte per offset. A write through any bank is read back through every bank from the next cycle.
- R6: An access to offset 00h to 1Fh of any bank does the following:
  - it raises sfrSel;
  - it sets sfrAddr to dataAddr;
  - it copies rdEn to sfrRd, wrEn to sfrWr and wrData to sfrWrData;
  - it returns sfrRdData on rdData;
  - it writes no RAM.
  Outside this range sfrSel, sfrRd and sfrWr are low and sfrAddr and sfrWrData are zero.
- R7: The holes are bank 1 offsets 40h to 6Fh, bank 2 offsets 20h to 6Fh and bank 3 offsets 20h to 6Fh. A read of a hole returns zero.
- R8: A write to a hole changes no RAM byte.
- R9: While rdEn is low, rdData is zero.
- R10: After reset, every RAM byte reads as zero.
- R11: Reads are combinational and writes take effect at the rising clock edge. A read and a write to the same byte in the same cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| indirectMode | input | 1 | 1: address comes from the pointer; 0: address comes from the operand |
| opAddr | input | 7 | Instruction operand offset |
| fileSel | input | 8 | File-select pointer |
| bankSel | input | 2 | Status bank bits, bit 1 = status bit 6, bit 0 = status bit 5 |
| indBank | input | 1 | Status indirect bank bit (status bit 7) |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| dataAddr | output | 9 | Formed 9-bit address |
| sfrSel | output | 1 | Special-register access in progress |
| sfrAddr | output | 9 | Special-register address |
| sfrRd | output | 1 | Special-register read strobe |
| sfrWr | output | 1 | Special-register write strobe |
| sfrWrData | output | 8 | Special-register write data |
| sfrRdData | input | 8 | Data returned by the special registers |

## Verification
Some behaviours are checked by assertions on every cycle:
- a read of a hole returns zero;
- a special-region read passes sfrRdData through;
- a write to a hole or to a special offset leaves both RAM arrays unchanged;
- the special-register strobes appear only with a matching request;
- rdData stays at zero while no read is requested.

Other behaviours need the bench's scenarios and reference model:
- address formation in both modes;
- bank 0 and bank 1 RAM holding their own contents;
- the shared window behaving as one byte when reached from all four banks;
- the contents after reset;
- a read in the same cycle as a write returning the old value.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  localparam int OFF_W = 7;

  typedef struct packed {
    logic                 sfrHit;
    logic                 ramB0;
    logic                 ramB1;
    logic                 hole;
    logic                 rd;
    logic                 wr;
    logic [OFF_W-1:0]     offset;
  } bankStrobe_t;
endpackage

// File: rtl/bankdec_ctrl.sv
module bankdec_ctrl
  import bankdec_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SFR_SPAN    = 32,
  parameter int SHARED_SPAN = 16,
  parameter int B1_SPAN     = 32
) (
  input  logic                      indirectMode,
  input  logic [OFF_W-1:0]          opAddr,
  input  logic [OFF_W:0]            fileSel,
  input  logic [BANK_W-1:0]         bankSel,
  input  logic                      indBank,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  output logic [BANK_W+OFF_W-1:0]   dataAddr,
  output logic                      sfrSel,
  output logic [BANK_W+OFF_W-1:0]   sfrAddr,
  output logic                      sfrRd,
  output logic                      sfrWr,
  output logic [DATA_W-1:0]         sfrWrData,
  output bankStrobe_t               strb
);
  localparam int ADDR_W      = BANK_W + OFF_W;
  localparam int BANK_SPAN   = 1 << OFF_W;
  localparam int SHARED_BASE = BANK_SPAN - SHARED_SPAN;
  localparam int B1_TOP      = SFR_SPAN + B1_SPAN;

  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              inSfr, inShared, active;

  // the indirect path carries one bank bit above an 8-bit pointer
  assign addr   = indirectMode ? {indBank, fileSel} : {bankSel, opAddr};
  assign bank   = addr[ADDR_W-1:OFF_W];
  assign off    = addr[OFF_W-1:0];
  assign active = rdEn | wrEn;

  assign inSfr    = (32'(off) < SFR_SPAN);
  assign inShared = (32'(off) >= SHARED_BASE);

  always_comb begin
    strb        = '0;
    strb.sfrHit = inSfr;
    strb.ramB0  = !inSfr && (inShared || bank == BANK_W'(0));
    strb.ramB1  = !inSfr && !inShared && bank == BANK_W'(1) && (32'(off) < B1_TOP);
    strb.hole   = !inSfr && !strb.ramB0 && !strb.ramB1;
    strb.rd     = rdEn;
    strb.wr     = wrEn;
    strb.offset = off;
  end

  assign dataAddr  = addr;
  assign sfrSel    = inSfr & active;
  assign sfrAddr   = sfrSel ? addr : '0;
  assign sfrRd     = inSfr & rdEn;
  assign sfrWr     = inSfr & wrEn;
  assign sfrWrData = sfrWr ? wrData : '0;
endmodule

// File: rtl/bankdec_datapath.sv
module bankdec_datapath
  import bankdec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SFR_SPAN = 32,
  parameter int B1_SPAN  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sfrRdData,
  output logic [DATA_W-1:0] rdData
);
  localparam int B0_DEPTH = (1 << OFF_W) - SFR_SPAN;
  localparam int B1_IW    = $clog2(B1_SPAN);

  logic [B0_DEPTH-1:0][DATA_W-1:0] b0Mem;
  logic [B1_SPAN-1:0][DATA_W-1:0]  b1Mem;
  logic [OFF_W-1:0]                idx;
  logic [B1_IW-1:0]                b1Idx;

  // bank 0 index also serves the shared window of all banks
  assign idx   = strb.offset - OFF_W'(SFR_SPAN);
  assign b1Idx = idx[B1_IW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b0Mem <= '0;
      b1Mem <= '0;
    end else begin
      if (strb.wr && strb.ramB0) b0Mem[idx]   <= wrData;
      if (strb.wr && strb.ramB1) b1Mem[b1Idx] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rd) begin
      if (strb.sfrHit)     rdData = sfrRdData;
      else if (strb.ramB0) rdData = b0Mem[idx];
      else if (strb.ramB1) rdData = b1Mem[b1Idx];
    end
  end

  a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.hole) |-> rdData == '0);
  a_r6_sfr_data_passes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sfrHit) |-> rdData == sfrRdData);
  a_r8_hole_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.hole) |=> ($stable(b0Mem) && $stable(b1Mem)));
  a_r6_sfr_write_no_ram: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.sfrHit) |=> ($stable(b0Mem) && $stable(b1Mem)));
endmodule

// File: rtl/banked_file_decoder.sv
module banked_file_decoder
  import bankdec_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SFR_SPAN    = 32,
  parameter int SHARED_SPAN = 16,
  parameter int B1_SPAN     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    indirectMode,
  input  logic [OFF_W-1:0]        opAddr,
  input  logic [OFF_W:0]          fileSel,
  input  logic [BANK_W-1:0]       bankSel,
  input  logic                    indBank,
  input  logic                    rdEn,
  input  logic                    wrEn,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic [BANK_W+OFF_W-1:0] dataAddr,
  output logic                    sfrSel,
  output logic [BANK_W+OFF_W-1:0] sfrAddr,
  output logic                    sfrRd,
  output logic                    sfrWr,
  output logic [DATA_W-1:0]       sfrWrData,
  input  logic [DATA_W-1:0]       sfrRdData
);
  bankStrobe_t strb;

  bankdec_ctrl #(
    .BANK_W(BANK_W), .DATA_W(DATA_W), .SFR_SPAN(SFR_SPAN),
    .SHARED_SPAN(SHARED_SPAN), .B1_SPAN(B1_SPAN)
  ) ctrl_i (
    .indirectMode(indirectMode), .opAddr(opAddr), .fileSel(fileSel),
    .bankSel(bankSel), .indBank(indBank), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .dataAddr(dataAddr), .sfrSel(sfrSel), .sfrAddr(sfrAddr),
    .sfrRd(sfrRd), .sfrWr(sfrWr), .sfrWrData(sfrWrData), .strb(strb)
  );

  bankdec_datapath #(
    .DATA_W(DATA_W), .SFR_SPAN(SFR_SPAN), .B1_SPAN(B1_SPAN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .sfrRdData(sfrRdData), .rdData(rdData)
  );

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
  a_r6_sfr_rd_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    sfrRd |-> (rdEn && sfrSel));
  a_r6_sfr_wr_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    sfrWr |-> (wrEn && sfrSel));
  a_r6_sfr_addr_matches: assert property (@(posedge clk) disable iff (!rstN)
    sfrSel |-> (sfrAddr == dataAddr && 32'(dataAddr[OFF_W-1:0]) < SFR_SPAN));
endmodule

// File: tb/banked_file_decoder_tb_top.sv
module banked_file_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       indirectMode = 1'b0;
  logic [6:0] opAddr = '0;
  logic [7:0] fileSel = '0;
  logic [1:0] bankSel = '0;
  logic       indBank = 1'b0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0, sfrRdData = '0;
  logic [7:0] rdData, sfrWrData;
  logic [8:0] dataAddr, sfrAddr;
  logic       sfrSel, sfrRd, sfrWr;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m0 [96];
  logic [7:0] m1 [32];

  always #4 clk = ~clk;

  banked_file_decoder dut_i (
    .clk(clk), .rstN(rstN), .indirectMode(indirectMode), .opAddr(opAddr),
    .fileSel(fileSel), .bankSel(bankSel), .indBank(indBank), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .dataAddr(dataAddr),
    .sfrSel(sfrSel), .sfrAddr(sfrAddr), .sfrRd(sfrRd), .sfrWr(sfrWr),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData)
  );

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic logic [8:0] expAddr(input logic ind, input logic [6:0] op,
                                         input logic [7:0] fs, input logic [1:0] bs,
                                         input logic ib);
    return ind ? {ib, fs} : {bs, op};
  endfunction

  // 0 sfr, 1 bank0/shared, 2 bank1, 3 hole
  function automatic int region(input logic [8:0] a);
    int off = int'(a[6:0]);
    if (off < 32) return 0;
    if (off >= 112 || a[8:7] == 2'd0) return 1;
    if (a[8:7] == 2'd1 && off < 64) return 2;
    return 3;
  endfunction

  function automatic string reqOf(input logic [8:0] a);
    case (region(a))
      0: return "R6";
      1: return (a[6:0] >= 7'h70) ? "R5" : "R3";
      2: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [8:0] a, input logic rd,
                                         input logic [7:0] sfrIn);
    if (!rd) return 8'h00;
    case (region(a))
      0: return sfrIn;
      1: return m0[int'(a[6:0]) - 32];
      2: return m1[int'(a[6:0]) - 32];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic ind, input logic [6:0] op, input logic [7:0] fs,
                        input logic [1:0] bs, input logic ib, input logic rd,
                        input logic wr, input logic [7:0] wd, input logic [7:0] sIn,
                        input string tag);
    logic [8:0] a;
    logic       inS;
    @(negedge clk);
    indirectMode = ind; opAddr = op; fileSel = fs; bankSel = bs; indBank = ib;
    rdEn = rd; wrEn = wr; wrData = wd; sfrRdData = sIn;
    a   = expAddr(ind, op, fs, bs, ib);
    inS = (region(a) == 0);
    #1;
    check(ind ? "R2" : "R1", {tag, " addr"}, 16'(dataAddr), 16'(a));
    check(rd ? reqOf(a) : "R9", {tag, " rdData"}, 16'(rdData), 16'(expRead(a, rd, sIn)));
    check("R6", {tag, " sfr strobes"}, {12'(0), sfrSel, sfrRd, sfrWr, 1'b0},
          {12'(0), inS & (rd | wr), inS & rd, inS & wr, 1'b0});
    check("R6", {tag, " sfr addr/data"}, {sfrAddr[7:0], sfrWrData},
          {(inS & (rd | wr)) ? a[7:0] : 8'h00, (inS & wr) ? wd : 8'h00});
    @(posedge clk);
    if (wr) begin
      case (region(a))
        1: m0[int'(a[6:0]) - 32] = wd;
        2: m1[int'(a[6:0]) - 32] = wd;
        default: ;
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 96; i++) m0[i] = 8'h00;
    for (int i = 0; i < 32; i++) m1[i] = 8'h00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R10: every RAM byte is zero after reset
    for (int i = 32; i < 128; i++) access(1'b0, 7'(i), 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R10 bank0");
    for (int i = 32; i < 64; i++)  access(1'b1, 7'h00, 8'(128 + i), 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R10 bank1");

    // R3/R4: bank 0 and bank 1 keep separate contents at the same offset
    access(1'b0, 7'h25, 8'h00, 2'd0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h00, "R3 write");
    access(1'b0, 7'h25, 8'h00, 2'd1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h00, "R4 write");
    access(1'b0, 7'h25, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R3 read");
    access(1'b1, 7'h00, 8'hA5, 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R4 read");

    // R5: write through bank 3, read through every bank
    access(1'b0, 7'h75, 8'h00, 2'd3, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h00, "R5 write b3");
    for (int b = 0; b < 4; b++) access(1'b0, 7'h75, 8'h00, 2'(b), 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R5 alias read");
    access(1'b1, 7'h00, 8'hF5, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R5 indirect 1F5");

    // R7/R8: hole write ignored, hole reads zero
    access(1'b0, 7'h25, 8'h00, 2'd3, 1'b0, 1'b0, 1'b1, 8'hEE, 8'h00, "R8 hole write");
    access(1'b0, 7'h25, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R7 hole read");
    access(1'b0, 7'h25, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R8 bank0 intact");
    access(1'b0, 7'h45, 8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R7 bank1 hole");

    // R6: special-register port, write does not touch RAM
    access(1'b0, 7'h03, 8'h00, 2'd2, 1'b0, 1'b1, 1'b1, 8'h77, 8'h9C, "R6 sfr rw");
    access(1'b1, 7'h00, 8'h1F, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3D, "R6 sfr indirect");

    // R11: same-cycle read and write return the old value
    access(1'b0, 7'h30, 8'h00, 2'd0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h00, "R11 rw first");
    access(1'b0, 7'h30, 8'h00, 2'd0, 1'b0, 1'b1, 1'b1, 8'h22, 8'h00, "R11 rw second");
    access(1'b0, 7'h30, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R11 read after");

    // R9: no read, no data
    access(1'b0, 7'h30, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h55, "R9 idle");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom();
      access(r[0], r[7:1], r[15:8], r[17:16], r[18], r[19], r[20] & r[21],
             r[29:22], 8'(r[31:24] ^ r[7:0]), "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule